// File: doc/BRIEF.md
# Exception Context Swap Sequencer

This block is the hardwired control for taking an exception in a single-bus machine. At an instruction boundary it may accept one of two causes: a program-check violation or a timer timeout. It then saves the running status word and program counter to a small, fixed block of low memory. After that it fetches a replacement status word and program counter from the same block. Every move crosses one shared 16-bit bus, and only one source drives that bus in any step. Memory is asynchronous and byte addressed, so a read or a write finishes inside the step that issues it.

Each cause owns four consecutive words. The program-check block starts at byte 0 and the timeout block starts at byte 8. Each of the four transfers takes two steps. The first step puts a vector address from a constant source onto the bus and latches it into the memory address register. The second step moves the data between memory and the status word or program counter. Outside an exception, the rest of the machine updates the status word and program counter through an external load port. The block pulses `done` once the new program counter is in place, and instruction fetch then resumes.

Top module: `excSwapSeq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `memRd` and `memWr` are low, `memAddr` is 0, `pc` is 0 and `psw` is 0x0004 (privileged).
- R2: A program-check swap writes `psw` to byte address 0, then writes `pc` to 2, then loads `psw` from 4, then loads `pc` from 6, in exactly that order. Every word address it uses is even.
- R3: A timeout swap uses the same order at byte addresses 8, 10, 12 and 14.
- R4: A swap starts only on a clock edge where the block is idle and `atBoundary` is high. A pending request with `atBoundary` low starts nothing.
- R5: A timeout request (`timeoutFlag`) is ignored while bit 2 of `psw` (the privileged bit) is 1.
- R6: If both causes are eligible at the same boundary, the program check is served (`svcTimer` = 0). `svcTimer` = 1 marks a timeout swap while `busy` is high.
- R7: Requests that arrive while a swap is in progress have no effect on that swap.
- R8: A swap keeps `busy` high for 8 cycles: steps 0 to 7, with odd steps doing data transfers. `done` is high for exactly one cycle, the cycle after the final `pc` load, and `busy` is low in that cycle.
- R9: Each step holds at most one memory strobe. Steps 1 and 3 write, steps 5 and 7 read, and each strobe step comes straight after an address step.
- R10: `extLoad` copies `extPsw` and `extPc` on a clock edge only while the block is idle. While busy it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| atBoundary | input | 1 | High when control sits between two instructions |
| progCheckReq | input | 1 | Program-check violation pending |
| timeoutFlag | input | 1 | Timer expired state bit |
| extLoad | input | 1 | Execution logic writes status word and PC |
| extPsw | input | 16 | Status word value for extLoad |
| extPc | input | 16 | Program counter value for extLoad |
| memRdData | input | 16 | Asynchronous memory read word |
| memAddr | output | 16 | Byte address from the memory address register |
| memWrData | output | 16 | Bus value offered as write data |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| psw | output | 16 | Current status word |
| pc | output | 16 | Current program counter |
| busy | output | 1 | Swap in progress |
| done | output | 1 | One-cycle pulse after the new PC is loaded |
| svcTimer | output | 1 | Cause of the current swap: 1 for timeout |

## Verification
The bench first raises a program check with `atBoundary` held low. A design that ignored the boundary would start swapping in the middle of an instruction. It also sets a timeout while privileged. A design that skipped the mask would save context to the timeout block when it should do nothing. Both causes are then raised together, which exposes a wrong priority as stores to bytes 8 and 10 instead of 0 and 2. Requests and external loads are applied in the middle of a swap to catch a sequencer that restarts, or a status word that is overwritten before it is saved. The saved memory words are read back at the end to confirm that the old values landed at the right vector slots.

// File: rtl/excSwapPkg.sv
package excSwapPkg;
  localparam int DATA_W    = 16;
  localparam int NUM_CONST = 8;
  localparam int IDX_W     = $clog2(NUM_CONST);

  typedef struct packed {
    logic             drvConst;
    logic             drvPsw;
    logic             drvPc;
    logic             drvMem;
    logic             ldMar;
    logic             ldPsw;
    logic             ldPc;
    logic             memRd;
    logic             memWr;
    logic             lockExt;
    logic [IDX_W-1:0] constIdx;
  } swapCtl_t;
endpackage

// File: rtl/swapCtrl.sv
module swapCtrl
  import excSwapPkg::*;
#(
  parameter int PRIV_BIT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        atBoundary,
  input  logic        progCheckReq,
  input  logic        timeoutFlag,
  input  logic        privIn,
  output swapCtl_t    ctl,
  output logic        busy,
  output logic        done,
  output logic        svcTimer
);
  localparam int STEP_W = 3;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t            state;
  logic [STEP_W-1:0] step;
  logic              causeTmr;
  logic              doneQ;
  logic              tmrOk;
  logic              startNow;

  assign tmrOk    = timeoutFlag && !privIn;
  assign startNow = (state == ST_IDLE) && atBoundary && (progCheckReq || tmrOk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      step     <= '0;
      causeTmr <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (startNow) begin
        state    <= ST_RUN;
        step     <= '0;
        causeTmr <= !progCheckReq;
      end else if (state == ST_RUN) begin
        if (step == STEP_W'(7)) begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl = '0;
    if (state == ST_RUN) begin
      ctl.lockExt  = 1'b1;
      ctl.constIdx = {causeTmr, step[2:1]};
      if (!step[0]) begin
        ctl.drvConst = 1'b1;
        ctl.ldMar    = 1'b1;
      end else begin
        unique case (step[2:1])
          2'd0: begin ctl.drvPsw = 1'b1; ctl.memWr = 1'b1; end
          2'd1: begin ctl.drvPc  = 1'b1; ctl.memWr = 1'b1; end
          2'd2: begin ctl.drvMem = 1'b1; ctl.memRd = 1'b1; ctl.ldPsw = 1'b1; end
          default: begin ctl.drvMem = 1'b1; ctl.memRd = 1'b1; ctl.ldPc = 1'b1; end
        endcase
      end
    end
  end

  assign busy     = (state == ST_RUN);
  assign done     = doneQ;
  assign svcTimer = causeTmr;

  AST_START_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(atBoundary)); // R4
  AST_TMR_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && svcTimer) |-> !$past(privIn)); // R5
  AST_PCHK_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && $past(progCheckReq)) |-> !svcTimer); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8
  AST_STROBE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memRd || ctl.memWr) |-> $past(ctl.ldMar)); // R9
endmodule

// File: rtl/swapDp.sv
module swapDp
  import excSwapPkg::*;
#(
  parameter int               WORD_BYTES = 2,
  parameter logic [DATA_W-1:0] RESET_PSW = 16'h0004
) (
  input  logic              clk,
  input  logic              rstN,
  input  swapCtl_t          ctl,
  input  logic              extLoad,
  input  logic [DATA_W-1:0] extPsw,
  input  logic [DATA_W-1:0] extPc,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] psw,
  output logic [DATA_W-1:0] pc
);
  logic [DATA_W-1:0] constTbl [NUM_CONST];
  logic [DATA_W-1:0] bus;
  logic [DATA_W-1:0] mar;
  logic              extOk;

  for (genvar i = 0; i < NUM_CONST; i++) begin : g_const
    assign constTbl[i] = DATA_W'(i * WORD_BYTES);
  end

  always_comb begin
    bus = '0;
    if (ctl.drvConst) bus = constTbl[ctl.constIdx];
    if (ctl.drvPsw)   bus = psw;
    if (ctl.drvPc)    bus = pc;
    if (ctl.drvMem)   bus = memRdData;
  end

  assign extOk = extLoad && !ctl.lockExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mar <= '0;
      psw <= RESET_PSW;
      pc  <= '0;
    end else begin
      if (ctl.ldMar) mar <= bus;
      if (ctl.ldPsw)  psw <= bus;
      else if (extOk) psw <= extPsw;
      if (ctl.ldPc)   pc  <= bus;
      else if (extOk) pc  <= extPc;
    end
  end

  assign memAddr   = mar;
  assign memWrData = bus;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.drvConst, ctl.drvPsw, ctl.drvPc, ctl.drvMem})); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.memRd && ctl.memWr)); // R9
  AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memRd || ctl.memWr) |-> !memAddr[0]); // R2
  AST_PSW_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lockExt && !ctl.ldPsw) |=> $stable(psw)); // R10
  AST_PC_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lockExt && !ctl.ldPc) |=> $stable(pc)); // R10
endmodule

// File: rtl/excSwapSeq.sv
module excSwapSeq
  import excSwapPkg::*;
#(
  parameter int PRIV_BIT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        atBoundary,
  input  logic        progCheckReq,
  input  logic        timeoutFlag,
  input  logic        extLoad,
  input  logic [15:0] extPsw,
  input  logic [15:0] extPc,
  input  logic [15:0] memRdData,
  output logic [15:0] memAddr,
  output logic [15:0] memWrData,
  output logic        memRd,
  output logic        memWr,
  output logic [15:0] psw,
  output logic [15:0] pc,
  output logic        busy,
  output logic        done,
  output logic        svcTimer
);
  swapCtl_t ctl;

  swapCtrl #(.PRIV_BIT(PRIV_BIT)) uCtrl (
    .clk(clk), .rstN(rstN), .atBoundary(atBoundary),
    .progCheckReq(progCheckReq), .timeoutFlag(timeoutFlag),
    .privIn(psw[PRIV_BIT]), .ctl(ctl), .busy(busy), .done(done),
    .svcTimer(svcTimer)
  );

  swapDp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .extLoad(extLoad),
    .extPsw(extPsw), .extPc(extPc), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .psw(psw), .pc(pc)
  );

  assign memRd = ctl.memRd;
  assign memWr = ctl.memWr;
endmodule

// File: tb/sim_excSwapSeq.sv
module sim_excSwapSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        atBoundary = 1'b0, progCheckReq = 1'b0, timeoutFlag = 1'b0;
  logic        extLoad = 1'b0;
  logic [15:0] extPsw = '0, extPc = '0;
  logic [15:0] memRdData, memAddr, memWrData, psw, pc;
  logic        memRd, memWr, busy, done, svcTimer;

  int nVec = 0, nBad = 0;
  bit finished = 0;

  logic [7:0] mem [32];

  int          mStep;
  bit          mTmr, mDone;
  logic [15:0] mPsw, mPc, mMar;

  always #5 clk = ~clk;

  excSwapSeq u0 (.*);

  assign memRdData = {mem[5'(memAddr[4:0] + 5'd1)], mem[memAddr[4:0]]};

  always @(posedge clk)
    if (memWr) begin
      mem[memAddr[4:0]]                <= memWrData[7:0];
      mem[5'(memAddr[4:0] + 5'd1)]     <= memWrData[15:8];
    end

  function automatic logic [15:0] rdWord(input logic [15:0] a);
    return {mem[5'(a[4:0] + 5'd1)], mem[a[4:0]]};
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mStep = -1; mTmr = 0; mDone = 0;
      mPsw = 16'h0004; mPc = 0; mMar = 0;
    end else begin
      automatic bit nd = 0;
      automatic int base;
      if (mStep < 0) begin
        automatic bit go = atBoundary && (progCheckReq || (timeoutFlag && !mPsw[2]));
        if (extLoad) begin mPsw = extPsw; mPc = extPc; end
        if (go) begin mStep = 0; mTmr = !progCheckReq; end
      end else begin
        base = mTmr ? 8 : 0;
        case (mStep)
          0: mMar = 16'(base);
          2: mMar = 16'(base + 2);
          4: mMar = 16'(base + 4);
          5: mPsw = rdWord(mMar);
          6: mMar = 16'(base + 6);
          7: begin mPc = rdWord(mMar); nd = 1; end
          default: ;
        endcase
        mStep = (mStep == 7) ? -1 : mStep + 1;
      end
      mDone = nd;
    end
  end

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN && !finished) begin
    automatic bit eBusy = (mStep >= 0);
    automatic bit eWr = (mStep == 1) || (mStep == 3);
    automatic bit eRd = (mStep == 5) || (mStep == 7);
    automatic string aTag = mTmr ? "R3" : "R2";
    chk("R8", "busy", 16'(busy), 16'(eBusy));
    chk("R8", "done", 16'(done), 16'(mDone));
    chk("R9", "memWr", 16'(memWr), 16'(eWr));
    chk("R9", "memRd", 16'(memRd), 16'(eRd));
    chk(aTag, "memAddr", memAddr, mMar);
    chk("R10", "psw", psw, mPsw);
    chk("R10", "pc", pc, mPc);
    if (eBusy) chk("R6", "svcTimer", 16'(svcTimer), 16'(mTmr));
    if (eWr) chk(aTag, "memWrData", memWrData, (mStep == 1) ? mPsw : mPc);
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic setWord(int a, logic [15:0] v);
    mem[a] = v[7:0]; mem[a+1] = v[15:8];
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    setWord(4, 16'h0004); setWord(6, 16'h0100);
    setWord(12, 16'h0004); setWord(14, 16'h0200);
    step(2);
    // R1 reset state
    chk("R1", "busy", 16'(busy), 0); chk("R1", "done", 16'(done), 0);
    chk("R1", "memRd", 16'(memRd), 0); chk("R1", "memWr", 16'(memWr), 0);
    chk("R1", "memAddr", memAddr, 0); chk("R1", "pc", pc, 0);
    chk("R1", "psw", psw, 16'h0004);
    rstN = 1'b1;
    step(1);
    // R10 external load while idle: user mode
    extLoad = 1; extPsw = 16'h8001; extPc = 16'h1234; step(1); extLoad = 0;
    chk("R10", "pc after extLoad", pc, 16'h1234);
    // R4 request without boundary
    progCheckReq = 1; step(4);
    chk("R4", "busy without boundary", 16'(busy), 0);
    atBoundary = 1; step(1); atBoundary = 0; progCheckReq = 0;
    chk("R4", "busy after boundary", 16'(busy), 1);
    // R7 / R10 disturbances mid swap
    step(2);
    timeoutFlag = 1; atBoundary = 1; extLoad = 1; extPsw = 16'hDEAD; extPc = 16'hBEEF;
    step(2);
    extLoad = 0; timeoutFlag = 0; atBoundary = 0;
    step(6);
    chk("R7", "svcTimer kept", 16'(svcTimer), 0);
    chk("R2", "saved psw @0", rdWord(0), 16'h8001);
    chk("R2", "saved pc @2", rdWord(2), 16'h1234);
    chk("R2", "new pc", pc, 16'h0100);
    chk("R2", "new psw", psw, 16'h0004);
    // R5 timeout ignored while privileged
    timeoutFlag = 1; atBoundary = 1; step(5);
    chk("R5", "busy while privileged", 16'(busy), 0);
    chk("R5", "pc unchanged", pc, 16'h0100);
    timeoutFlag = 0; atBoundary = 0;
    // R3 timeout in user mode
    extLoad = 1; extPsw = 16'h0002; extPc = 16'h2222; step(1); extLoad = 0;
    timeoutFlag = 1; atBoundary = 1; step(1); atBoundary = 0; timeoutFlag = 0;
    chk("R3", "svcTimer", 16'(svcTimer), 1);
    step(9);
    chk("R3", "saved psw @8", rdWord(8), 16'h0002);
    chk("R3", "saved pc @10", rdWord(10), 16'h2222);
    chk("R3", "new pc", pc, 16'h0200);
    // R6 both causes pending
    extLoad = 1; extPsw = 16'h0001; extPc = 16'h3333; step(1); extLoad = 0;
    timeoutFlag = 1; progCheckReq = 1; atBoundary = 1; step(1);
    atBoundary = 0; timeoutFlag = 0; progCheckReq = 0;
    chk("R6", "svcTimer both", 16'(svcTimer), 0);
    step(9);
    chk("R6", "pchk saved pc @2", rdWord(2), 16'h3333);
    chk("R6", "tmr slot untouched @10", rdWord(10), 16'h2222);
    step(3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      nVec++; nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule